// File: doc/BRIEF.md
# Dual Transmit Buffer Controller

This block holds one or two transmit frame buffers in a memory-mapped window and hands each one to a byte-wide transmit stream. Software fills a buffer with 32-bit data writes, programs its byte count, then sets a busy flag in that buffer's status word. The controller streams the frame one byte at a time over a valid/ready interface and clears busy once the last byte has been taken. If interrupts are enabled, it then raises a completion pulse.

The same status word can also act as a load command for the station address. When software sets the busy and load flags together, the controller copies the first six bytes of the buffer into a 48-bit station address register. No bytes are sent in that case. If both buffers are started, they are served in the order in which software started them.

Top module: `tx_pingpong_ctrl`

## Requirements
- R1: After reset, every status word, every length register and the global enable read 0, `irq` is low, `tx_valid` is low and `station_addr` is 0.
- R2: Byte address bit 11 selects the buffer, so the second buffer sits 0x800 above the first. Inside a window, data words start at offset 0, with buffer byte 0 in data bits 7:0. The length register is at offset 0x7F4 and keeps only bits 15:0 (the upper bits read 0). The status word is at 0x7FC. The global interrupt enable is bit 31 of offset 0x7F8, and only in the first window; that offset in the second window reads 0.
- R3: Writing a status word with bit 0 = 1 and bit 1 = 0 to an idle buffer sends exactly length bytes in ascending byte order. `tx_last` marks the final byte. `tx_data` and `tx_last` hold steady while `tx_ready` is low.
- R4: Status bit 0 reads 1 from the start write until the last byte is accepted, and hardware then clears it. A write with bit 0 = 0 does not clear it. A write with bit 0 = 1 to a busy buffer does not start another transmission.
- R5: Setting status bits 0 and 1 together loads `station_addr` from buffer bytes 0..5. Byte 0 goes to bits 47:40 and byte 5 to bits 7:0. No byte is sent, and both bits then read 0.
- R6: `irq` is a one-cycle pulse in the cycle after a buffer's busy bit clears. It fires only when that buffer's status bit 3 and the global enable bit 31 are both 1.
- R7: Status bit 31 is stored and read back with no effect on transmission. Bit 3 also reads back as written.
- R8: When both buffers are busy, their frames are sent whole, one after the other, in the order their start writes arrived.
- R9: A length of 0 sends no byte and busy still clears. A length above the data capacity of a window (2036 bytes by default) is cut down to that capacity. The length register itself still reads back the value written.
- R10: With one buffer configured, the second window reads 0 and writes to it have no effect, so a start written there sends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address into the register space |
| bus_wr | input | 1 | Write strobe for one full 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tx_valid | output | 1 | A frame byte is offered |
| tx_ready | input | 1 | The sink takes the offered byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | The offered byte ends the frame |
| station_addr | output | 48 | Loaded station address |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The bench builds two copies. The first uses the default two-buffer, 2048-byte window configuration. It reaches start ordering across buffers, a station-address load in the upper window, and length clamping at the full 2036-byte capacity. The second copy has a single buffer, which brings the dead upper window into reach. With it, the bench can show at the ports that a start written there sends nothing and reads back as zero.

// File: rtl/tx_pp_pkg.sv
package tx_pp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_MAC0,
    ST_MAC1,
    ST_FIN
  } eng_state_t;

  // Status word layout: [31] software flag, [3] irq enable, [1] load, [0] busy
  function automatic logic [31:0] status_word(input logic busy, input logic load,
                                              input logic ie, input logic swf);
    return {swf, 27'b0, ie, 1'b0, load, busy};
  endfunction

  function automatic logic [15:0] clamp_len(input logic [15:0] len, input logic [15:0] cap);
    return (len > cap) ? cap : len;
  endfunction

  function automatic logic [7:0] pick_byte(input logic [31:0] word, input logic [1:0] sel);
    return word[8*sel +: 8];
  endfunction

  // Buffer byte 0 becomes the most significant octet of the station address
  function automatic logic [47:0] addr_from_words(input logic [31:0] w0, input logic [15:0] w1);
    return {w0[7:0], w0[15:8], w0[23:16], w0[31:24], w1[7:0], w1[15:8]};
  endfunction

endpackage

// File: rtl/tx_pp_regs.sv
module tx_pp_regs
  import tx_pp_pkg::*;
#(
  parameter int NUM_BUF   = 2,
  parameter int WIN_WORDS = 512,
  parameter int ADDR_W    = 12,
  parameter int WORD_W    = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic                     eng_buf,
  input  logic [WORD_W-1:0]        eng_word,
  output logic [31:0]              eng_rdata,
  input  logic                     fin_evt,
  input  logic                     fin_idx,
  output logic                     start_evt,
  output logic                     start_idx,
  output logic [NUM_BUF-1:0]       busy_vec,
  output logic [NUM_BUF-1:0]       load_vec,
  output logic [NUM_BUF-1:0]       ie_vec,
  output logic [NUM_BUF-1:0][15:0] len_vec,
  output logic                     gie
);
  localparam int DATA_WORDS = WIN_WORDS - 3;
  localparam int LEN_WORD   = WIN_WORDS - 3;
  localparam int GIE_WORD   = WIN_WORDS - 2;
  localparam int STAT_WORD  = WIN_WORDS - 1;

  logic              sel_buf;
  logic [WORD_W-1:0] sel_word;
  logic              win_ok;
  logic              unused_lsb;
  logic [NUM_BUF-1:0] swf_vec;
  logic [NUM_BUF-1:0] start_vec;

  assign sel_buf    = bus_addr[ADDR_W-1];
  assign sel_word   = bus_addr[ADDR_W-2:2];
  assign win_ok     = (NUM_BUF > 1) || !sel_buf;
  assign unused_lsb = ^bus_addr[1:0];

  logic [31:0] mem [NUM_BUF][DATA_WORDS];

  always_ff @(posedge clk) begin
    if (bus_wr && win_ok && (sel_word < WORD_W'(DATA_WORDS)))
      mem[sel_buf][sel_word] <= bus_wdata;
  end

  assign eng_rdata = mem[eng_buf][eng_word];

  always_ff @(posedge clk) begin
    if (!rst_n)
      gie <= 1'b0;
    else if (bus_wr && !sel_buf && (sel_word == WORD_W'(GIE_WORD)))
      gie <= bus_wdata[31];
  end

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    logic        busy_q, load_q, ie_q, swf_q;
    logic [15:0] len_q;
    logic        hit_stat, hit_len;

    assign hit_stat     = bus_wr && (sel_buf == 1'(b)) && (sel_word == WORD_W'(STAT_WORD));
    assign hit_len      = bus_wr && (sel_buf == 1'(b)) && (sel_word == WORD_W'(LEN_WORD));
    assign start_vec[b] = hit_stat && bus_wdata[0] && !busy_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_q <= 1'b0;
        load_q <= 1'b0;
        ie_q   <= 1'b0;
        swf_q  <= 1'b0;
        len_q  <= '0;
      end else begin
        if (fin_evt && (fin_idx == 1'(b))) begin
          busy_q <= 1'b0;
          load_q <= 1'b0;
        end else if (start_vec[b]) begin
          busy_q <= 1'b1;
          load_q <= bus_wdata[1];
        end
        if (hit_stat) begin
          ie_q  <= bus_wdata[3];
          swf_q <= bus_wdata[31];
        end
        if (hit_len)
          len_q <= bus_wdata[15:0];
      end
    end

    assign busy_vec[b] = busy_q;
    assign load_vec[b] = load_q;
    assign ie_vec[b]   = ie_q;
    assign swf_vec[b]  = swf_q;
    assign len_vec[b]  = len_q;
  end

  assign start_evt = |start_vec;
  assign start_idx = sel_buf;

  always_comb begin
    bus_rdata = '0;
    if (win_ok) begin
      if (sel_word < WORD_W'(DATA_WORDS))
        bus_rdata = mem[sel_buf][sel_word];
      else if (sel_word == WORD_W'(LEN_WORD))
        bus_rdata = {16'h0, len_vec[sel_buf]};
      else if (sel_word == WORD_W'(GIE_WORD))
        bus_rdata = sel_buf ? 32'h0 : {gie, 31'b0};
      else
        bus_rdata = status_word(busy_vec[sel_buf], load_vec[sel_buf],
                                ie_vec[sel_buf], swf_vec[sel_buf]);
    end
  end

endmodule

// File: rtl/tx_pp_order.sv
module tx_pp_order #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic push_idx,
  input  logic pop,
  output logic head_vld,
  output logic head_idx
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] q;
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    wr_pos;

  assign wr_pos   = pop ? (cnt - CW'(1)) : cnt;
  assign head_vld = (cnt != '0);
  assign head_idx = q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q   <= '0;
      cnt <= '0;
    end else begin
      if (pop)
        for (int i = 0; i < DEPTH - 1; i++) q[i] <= q[i+1];
      if (push)
        for (int i = 0; i < DEPTH; i++)
          if (wr_pos == CW'(i)) q[i] <= push_idx;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

endmodule

// File: rtl/tx_pp_engine.sv
module tx_pp_engine
  import tx_pp_pkg::*;
#(
  parameter int NUM_BUF = 2,
  parameter int WORD_W  = 9,
  parameter int MAX_LEN = 2036
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     head_vld,
  input  logic                     head_idx,
  output logic                     pop,
  input  logic [NUM_BUF-1:0]       load_vec,
  input  logic [NUM_BUF-1:0][15:0] len_vec,
  output logic                     rd_buf,
  output logic [WORD_W-1:0]        rd_word,
  input  logic [31:0]              rd_data,
  output logic                     tx_valid,
  input  logic                     tx_ready,
  output logic [7:0]               tx_data,
  output logic                     tx_last,
  output logic [47:0]              station_addr,
  output logic                     fin_evt,
  output logic                     cur_idx
);
  eng_state_t  state;
  logic [15:0] cnt;
  logic [15:0] last_pos;
  logic [15:0] len_eff;
  logic [31:0] w0;

  assign len_eff  = clamp_len(len_vec[head_idx], 16'(MAX_LEN));
  assign pop      = (state == ST_IDLE) && head_vld;
  assign rd_buf   = cur_idx;
  assign rd_word  = cnt[WORD_W+1:2];
  assign tx_valid = (state == ST_SEND);
  assign tx_data  = pick_byte(rd_data, cnt[1:0]);
  assign tx_last  = tx_valid && (cnt == last_pos);
  assign fin_evt  = (state == ST_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      cnt          <= '0;
      last_pos     <= '0;
      cur_idx      <= 1'b0;
      w0           <= '0;
      station_addr <= '0;
    end else begin
      case (state)
        ST_IDLE: if (head_vld) begin
          cur_idx <= head_idx;
          cnt     <= '0;
          if (load_vec[head_idx])
            state <= ST_MAC0;
          else if (len_eff == '0)
            state <= ST_FIN;
          else begin
            last_pos <= len_eff - 16'd1;
            state    <= ST_SEND;
          end
        end
        ST_SEND: if (tx_ready) begin
          if (cnt == last_pos) state <= ST_FIN;
          else                 cnt   <= cnt + 16'd1;
        end
        ST_MAC0: begin
          w0    <= rd_data;
          cnt   <= 16'd4;
          state <= ST_MAC1;
        end
        ST_MAC1: begin
          station_addr <= addr_from_words(w0, rd_data[15:0]);
          state        <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tx_pingpong_ctrl.sv
module tx_pingpong_ctrl #(
  parameter  int NUM_BUF   = 2,
  parameter  int WIN_BYTES = 2048,
  localparam int ADDR_W    = $clog2(WIN_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic [47:0]       station_addr,
  output logic              irq
);
  localparam int WIN_WORDS = WIN_BYTES / 4;
  localparam int WORD_W    = $clog2(WIN_WORDS);
  localparam int MAX_LEN   = (WIN_WORDS - 3) * 4;

  logic                     start_evt, start_idx;
  logic                     fin_evt, cur_idx;
  logic                     head_vld, head_idx, pop;
  logic                     gie;
  logic [NUM_BUF-1:0]       busy_vec, load_vec, ie_vec;
  logic [NUM_BUF-1:0][15:0] len_vec;
  logic                     rd_buf;
  logic [WORD_W-1:0]        rd_word;
  logic [31:0]              rd_data;

  tx_pp_regs #(
    .NUM_BUF(NUM_BUF), .WIN_WORDS(WIN_WORDS), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_buf(rd_buf), .eng_word(rd_word), .eng_rdata(rd_data),
    .fin_evt(fin_evt), .fin_idx(cur_idx),
    .start_evt(start_evt), .start_idx(start_idx),
    .busy_vec(busy_vec), .load_vec(load_vec), .ie_vec(ie_vec),
    .len_vec(len_vec), .gie(gie)
  );

  tx_pp_order #(.DEPTH(NUM_BUF)) u_order (
    .clk(clk), .rst_n(rst_n),
    .push(start_evt), .push_idx(start_idx), .pop(pop),
    .head_vld(head_vld), .head_idx(head_idx)
  );

  tx_pp_engine #(
    .NUM_BUF(NUM_BUF), .WORD_W(WORD_W), .MAX_LEN(MAX_LEN)
  ) u_engine (
    .clk(clk), .rst_n(rst_n),
    .head_vld(head_vld), .head_idx(head_idx), .pop(pop),
    .load_vec(load_vec), .len_vec(len_vec),
    .rd_buf(rd_buf), .rd_word(rd_word), .rd_data(rd_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .station_addr(station_addr), .fin_evt(fin_evt), .cur_idx(cur_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= fin_evt && ie_vec[cur_idx] && gie;
  end

endmodule

// File: rtl/tx_pp_chk.sv
module tx_pp_chk #(
  parameter int NUM_BUF = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [NUM_BUF-1:0] busy_vec,
  input logic [NUM_BUF-1:0] load_vec,
  input logic               cur_idx,
  input logic               tx_valid,
  input logic               tx_ready,
  input logic [7:0]         tx_data,
  input logic               tx_last,
  input logic               irq
);
  p_hold_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  p_send_only_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> busy_vec[cur_idx]);

  p_busy_rise_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((busy_vec & ~$past(busy_vec)) != '0) |-> $past(bus_wr));

  p_load_sends_nothing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !load_vec[cur_idx]);

  p_irq_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (($past(busy_vec) & ~busy_vec) != '0));

  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

endmodule

bind tx_pingpong_ctrl tx_pp_chk #(.NUM_BUF(NUM_BUF)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
  .busy_vec(busy_vec), .load_vec(load_vec), .cur_idx(cur_idx),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_last(tx_last), .irq(irq)
);

// File: tb/test_tx_pingpong_ctrl.sv
`timescale 1ns/1ps
module test_tx_pingpong_ctrl;
  localparam int STAT = 'h7FC;
  localparam int LENR = 'h7F4;
  localparam int GIER = 'h7F8;
  localparam int UP   = 'h800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        wr0 = 1'b0, wr1 = 1'b0;
  logic [31:0] rdata0, rdata1;
  logic        tx_valid, tx_ready = 1'b1, tx_last;
  logic [7:0]  tx_data;
  logic [47:0] station_addr;
  logic        irq;
  logic        s_valid, s_last, s_irq;
  logic [7:0]  s_data;
  logic [47:0] s_station;

  int n_chk = 0, n_bad = 0;
  int cap_n = 0, last_n = 0, last_pos = -1, irq_n = 0, s_bytes = 0;
  int rdy_mode = 0;
  logic [7:0] cap [0:4095];

  always #2 clk = ~clk;

  tx_pingpong_ctrl i_tx_pingpong_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr0), .bus_wdata(wdata),
    .bus_rdata(rdata0), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .station_addr(station_addr), .irq(irq));

  tx_pingpong_ctrl #(.NUM_BUF(1)) i_tx_pingpong_ctrl_single (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr1), .bus_wdata(wdata),
    .bus_rdata(rdata1), .tx_valid(s_valid), .tx_ready(1'b1), .tx_data(s_data),
    .tx_last(s_last), .station_addr(s_station), .irq(s_irq));

  always @(posedge clk) begin
    if (tx_valid && tx_ready) begin
      cap[cap_n] = tx_data;
      if (tx_last) begin last_n++; last_pos = cap_n; end
      cap_n++;
    end
    if (irq) irq_n++;
    if (s_valid) s_bytes++;
  end

  always @(negedge clk)
    if (rdy_mode == 1) tx_ready <= 1'b0;
    else if (rdy_mode == 2) tx_ready <= ~tx_ready;
    else tx_ready <= 1'b1;

  function automatic logic [7:0] eb(int i, int seed);
    return 8'(i * 7 + seed);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int inst, int a, logic [31:0] d);
    @(negedge clk);
    addr = 12'(a); wdata = d;
    if (inst == 0) wr0 = 1'b1; else wr1 = 1'b1;
    @(negedge clk);
    wr0 = 1'b0; wr1 = 1'b0;
  endtask

  task automatic rd(int inst, int a, output logic [31:0] d);
    @(negedge clk);
    addr = 12'(a);
    #1;
    d = (inst == 0) ? rdata0 : rdata1;
  endtask

  task automatic fill(int inst, int base, int len, int seed);
    for (int w = 0; w < (len + 3) / 4; w++)
      wr(inst, base + 4 * w, {eb(4*w+3, seed), eb(4*w+2, seed), eb(4*w+1, seed), eb(4*w, seed)});
  endtask

  task automatic wait_idle(int inst, int base);
    logic [31:0] d;
    for (int k = 0; k < 6000; k++) begin
      rd(inst, base + STAT, d);
      if (!d[0]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic frame_ok(string tag, int start, int len, int seed);
    int bad = 0;
    for (int i = 0; i < len; i++) if (cap[start + i] !== eb(i, seed)) bad++;
    chk(tag, 64'(bad), 0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(0, STAT, d);      chk("R1 status0", d, 0);
    rd(0, UP + STAT, d); chk("R1 status1", d, 0);
    rd(0, LENR, d);      chk("R1 len0", d, 0);
    rd(0, GIER, d);      chk("R1 gie", d, 0);
    chk("R1 outputs", {irq, tx_valid, station_addr}, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    wr(0, UP + LENR, 32'hABCD_1234);
    rd(0, UP + LENR, d); chk("R2 len low16", d, 32'h1234);
    rd(0, LENR, d);      chk("R2 len separate", d, 0);
    wr(0, GIER, 32'hFFFF_FFFF);
    rd(0, GIER, d);      chk("R2 gie bit31", d, 32'h8000_0000);
    rd(0, UP + GIER, d); chk("R2 upper gie reads 0", d, 0);
    wr(0, UP + 4, 32'h5A5A_0001);
    rd(0, UP + 4, d);    chk("R2 data word", d, 32'h5A5A_0001);
    rd(0, 4, d);         chk("R2 lower untouched", d !== 32'h5A5A_0001, 1);
    wr(0, STAT, 32'h8000_0008);
    rd(0, STAT, d);      chk("R7 sw flag and ie readback", d, 32'h8000_0008);
    wr(0, GIER, 0);
  endtask

  task automatic t_send;
    logic [31:0] d;
    int c0 = cap_n, i0 = irq_n;
    fill(0, 0, 10, 3);
    wr(0, LENR, 10);
    wr(0, GIER, 32'h8000_0000);
    rdy_mode = 2;
    wr(0, STAT, 32'h8000_0009);
    rd(0, STAT, d); chk("R4 busy set", d[0], 1);
    wr(0, STAT, 32'h0000_0009);
    wr(0, STAT, 32'h0000_0008);
    rd(0, STAT, d); chk("R4 zero write keeps busy", d[0], 1);
    wait_idle(0, 0);
    repeat (30) @(negedge clk);
    rdy_mode = 0;
    chk("R3 byte count", cap_n - c0, 10);
    frame_ok("R3 byte order", c0, 10, 3);
    chk("R3 last position", last_pos, c0 + 9);
    rd(0, STAT, d); chk("R4 busy cleared", d, 32'h0000_0008);
    chk("R6 irq pulse", irq_n - i0, 1);
    chk("R7 flag no effect", cap_n - c0, 10);
  endtask

  task automatic t_irq_mask;
    int i0 = irq_n;
    wr(0, GIER, 0);
    wr(0, LENR, 3);
    wr(0, STAT, 32'h9);
    wait_idle(0, 0);
    chk("R6 no irq without global", irq_n - i0, 0);
    wr(0, GIER, 32'h8000_0000);
    wr(0, STAT, 32'h1);
    wait_idle(0, 0);
    chk("R6 no irq without buffer ie", irq_n - i0, 0);
  endtask

  task automatic t_load;
    logic [31:0] d;
    int c0 = cap_n;
    wr(0, UP + 0, 32'h3322_1102);
    wr(0, UP + 4, 32'hEEFF_5544);
    wr(0, UP + LENR, 6);
    wr(0, UP + STAT, 32'h3);
    wait_idle(0, UP);
    chk("R5 station addr", station_addr, 48'h0211_2233_4455);
    chk("R5 no bytes", cap_n - c0, 0);
    rd(0, UP + STAT, d); chk("R5 bits cleared", d, 0);
  endtask

  task automatic t_order;
    int c0 = cap_n, l0 = last_n;
    fill(0, UP, 4, 40);
    fill(0, 0, 5, 90);
    wr(0, UP + LENR, 4);
    wr(0, LENR, 5);
    rdy_mode = 1;
    wr(0, UP + STAT, 32'h1);
    wr(0, STAT, 32'h1);
    repeat (5) @(negedge clk);
    rdy_mode = 0;
    wait_idle(0, UP);
    wait_idle(0, 0);
    chk("R8 total bytes", cap_n - c0, 9);
    frame_ok("R8 first started first", c0, 4, 40);
    frame_ok("R8 second after", c0 + 4, 5, 90);
    chk("R8 two frame ends", last_n - l0, 2);
  endtask

  task automatic t_len;
    logic [31:0] d;
    int c0 = cap_n;
    wr(0, LENR, 0);
    wr(0, STAT, 32'h1);
    wait_idle(0, 0);
    rd(0, STAT, d);
    chk("R9 zero length", {d[0], 32'(cap_n - c0)}, 0);
    fill(0, 0, 2036, 11);
    wr(0, LENR, 32'hFFFF);
    rd(0, LENR, d); chk("R9 len stored", d, 32'hFFFF);
    c0 = cap_n;
    wr(0, STAT, 32'h1);
    wait_idle(0, 0);
    chk("R9 clamped count", cap_n - c0, 2036);
    chk("R9 clamped last", last_pos, c0 + 2035);
    frame_ok("R9 clamped data", c0, 2036, 11);
  endtask

  task automatic t_single;
    logic [31:0] d;
    wr(1, UP + LENR, 4);
    rd(1, UP + LENR, d); chk("R10 upper len reads 0", d, 0);
    wr(1, UP + STAT, 32'h1);
    repeat (20) @(negedge clk);
    rd(1, UP + STAT, d); chk("R10 upper status 0", d, 0);
    chk("R10 no bytes", s_bytes, 0);
    wr(1, 0, 32'h0403_0201);
    wr(1, LENR, 3);
    wr(1, STAT, 32'h1);
    wait_idle(1, 0);
    chk("R10 lower buffer works", s_bytes, 3);
  endtask

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_regmap;
    t_send;
    t_irq_mask;
    t_load;
    t_order;
    t_len;
    t_single;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule